// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a single-beat host request port and an external asynchronous static RAM with a 15-bit address and an 8-bit data bus. The host raises a request with a direction flag, an address and a write byte. The controller latches them and runs the RAM strobes through a fixed sequence of clock-cycle intervals. It then answers with a one-cycle done pulse and, for reads, the byte it sampled.

All device timing is expressed as integer counts of system clock cycles. Each count is the nanosecond minimum divided by the clock period and rounded up, and is never below 1. The counts cover the read access time, the output-enable access time, the write-enable pulse width, the data-to-write overlap and the bus turnaround after the RAM's outputs are switched off. The chip select, output enable and write enable outputs are active low. The data bus is split into a driven byte, a drive-enable flag and a returned byte, so that the pad tristate can be built outside the block.

Top module: `asram_ctrl`

## Requirements
- R1: During reset and whenever the block is idle, memCsN, memOeN and memWeN are all 1, while memDoutEn and rspDone are 0.
- R2: Only these strobe combinations appear. Standby is memCsN=1. A read is memCsN=0, memOeN=0, memWeN=1. A write is memCsN=0, memWeN=0, memOeN=1. memWeN is never 0 while memOeN is 0, and memDoutEn is never 1 while memOeN is 0.
- R3: The address and write byte are latched in the cycle the request is accepted. memAddr stays constant while memCsN is 0, and changes to reqAddr and reqWdata after acceptance have no effect on the access.
- R4: A read drives memCsN and memOeN low in the cycle after acceptance. It holds them low for READ_LEN = max(RC_CYC, OE_CYC) cycles and samples memDin at the end of the last of those cycles.
- R5: A write drives memWeN low in the cycle after acceptance for WRITE_LEN = max(WP_CYC, DW_CYC, RC_CYC-1) cycles. memDoutEn is 1 from the first of those cycles through the cycle after memWeN rises, and memDout carries the latched write byte throughout.
- R6: After a write, memCsN rises exactly one cycle after memWeN rises, never earlier.
- R7: After a read, rspDone pulses in the cycle after the last read cycle, while memCsN and memOeN return high. rspRdata then holds the sampled byte until the next read completes.
- R8: After a read's done cycle, the block spends TURN_CYC further cycles in standby before it can accept a request. memDoutEn never rises fewer than TURN_CYC cycles after memOeN went high.
- R9: A write reports rspDone in the cycle memWeN is back high with memCsN still low, i.e. WRITE_LEN+1 cycles after acceptance. A read reports it READ_LEN+1 cycles after acceptance.
- R10: A request is accepted only in the idle state. reqValid raised while an access is in progress is ignored: it produces no extra done pulse and leaves memAddr unchanged.
- R11: rspDone is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request strobe, taken only when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Host address |
| reqWdata | input | DATA_W | Host write byte |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdata | output | DATA_W | Byte from the most recent read |
| memAddr | output | ADDR_W | RAM address, held through each access |
| memCsN | output | 1 | RAM chip select, active low |
| memOeN | output | 1 | RAM output enable, active low |
| memWeN | output | 1 | RAM write enable, active low |
| memDout | output | DATA_W | Byte to drive onto the RAM data bus |
| memDoutEn | output | 1 | Enables the external bus driver for memDout |
| memDin | input | DATA_W | Byte received from the RAM data bus |

## Verification
The bound checker watches, every cycle, the rules that sit on the pins themselves. These are the legal strobe combinations, address stability under chip select, and the minimum low widths of output enable, write enable and chip select, each measured with a run-length counter. They also cover data driving across the write pulse, chip select rising no earlier than write enable, the turnaround gap before the driver turns on, and the single-cycle done pulse. Only the bench scenarios can show that the right byte reaches the right location and comes back. They also show that data is sampled late enough, because the bench's RAM model returns a garbage byte before the access time has elapsed. The remaining scenario checks cover the exact done latency, the ignored mid-access request and the effect of changing request inputs after acceptance.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_RDONE,
    ST_RECOV,
    ST_WRITE,
    ST_WHOLD
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;    // latch address and write byte
    logic capture;   // register the returned byte
    logic selAct;    // chip select asserted
    logic readAct;   // output enable asserted
    logic writeAct;  // write enable asserted
    logic drive;     // data driver enabled
    logic done;      // completion pulse
  } strobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctrl_fsm.sv
`timescale 1ns/1ps
module asram_ctrl_fsm
  import asram_pkg::*;
#(
  parameter int RC_CYC   = 2,
  parameter int OE_CYC   = 1,
  parameter int WP_CYC   = 2,
  parameter int DW_CYC   = 1,
  parameter int TURN_CYC = 1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqValid,
  input  logic    reqWrite,
  output strobe_t stb
);

  localparam int READ_LEN  = maxOf(RC_CYC, OE_CYC);
  localparam int WRITE_LEN = maxOf(maxOf(WP_CYC, DW_CYC), RC_CYC - 1);
  localparam int CNT_MAX   = maxOf(maxOf(READ_LEN, WRITE_LEN), TURN_CYC);
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  ctlState_e   state;
  logic [CNT_W-1:0] cnt;
  logic        cntZero;

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            if (reqWrite) begin
              state <= ST_WRITE;
              cnt   <= CNT_W'(WRITE_LEN - 1);
            end else begin
              state <= ST_READ;
              cnt   <= CNT_W'(READ_LEN - 1);
            end
          end
        end
        ST_READ: begin
          if (cntZero) state <= ST_RDONE;
          else         cnt   <= cnt - 1'b1;
        end
        ST_RDONE: begin
          state <= ST_RECOV;
          cnt   <= CNT_W'(TURN_CYC - 1);
        end
        ST_RECOV: begin
          if (cntZero) state <= ST_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        ST_WRITE: begin
          if (cntZero) state <= ST_WHOLD;
          else         cnt   <= cnt - 1'b1;
        end
        ST_WHOLD: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb          = '0;
    stb.accept   = (state == ST_IDLE) && reqValid;
    stb.capture  = (state == ST_READ) && cntZero;
    stb.selAct   = (state == ST_READ) || (state == ST_WRITE) || (state == ST_WHOLD);
    stb.readAct  = (state == ST_READ);
    stb.writeAct = (state == ST_WRITE);
    stb.drive    = (state == ST_WRITE) || (state == ST_WHOLD);
    stb.done     = (state == ST_RDONE) || (state == ST_WHOLD);
  end

endmodule

// File: rtl/asram_ctrl_dp.sv
`timescale 1ns/1ps
module asram_ctrl_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (stb.accept) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           rdataQ <= '0;
    else if (stb.capture) rdataQ <= memDin;
  end

  assign memAddr   = addrQ;
  assign memDout   = wdataQ;
  assign memDoutEn = stb.drive;
  assign memCsN    = ~stb.selAct;
  assign memOeN    = ~stb.readAct;
  assign memWeN    = ~stb.writeAct;
  assign rspDone   = stb.done;
  assign rspRdata  = rdataQ;

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int RC_CYC   = 2,
  parameter int OE_CYC   = 1,
  parameter int WP_CYC   = 2,
  parameter int DW_CYC   = 1,
  parameter int TURN_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  strobe_t stb;

  asram_ctrl_fsm #(
    .RC_CYC(RC_CYC), .OE_CYC(OE_CYC), .WP_CYC(WP_CYC),
    .DW_CYC(DW_CYC), .TURN_CYC(TURN_CYC)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite), .stb(stb)
  );

  asram_ctrl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .memDin(memDin),
    .memAddr(memAddr), .memDout(memDout), .memDoutEn(memDoutEn),
    .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN),
    .rspDone(rspDone), .rspRdata(rspRdata)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk #(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int RC_CYC   = 2,
  parameter int OE_CYC   = 1,
  parameter int WP_CYC   = 2,
  parameter int DW_CYC   = 1,
  parameter int TURN_CYC = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rspDone,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCsN,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memDoutEn
);

  localparam int CW = 16;
  localparam logic [CW-1:0] SAT = '1;

  // run lengths of the strobe levels, saturating
  logic [CW-1:0] csLowCnt, oeLowCnt, weLowCnt, oeHighCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csLowCnt  <= '0;
      oeLowCnt  <= '0;
      weLowCnt  <= '0;
      oeHighCnt <= CW'(TURN_CYC);
    end else begin
      csLowCnt  <= memCsN  ? '0 : ((csLowCnt  == SAT) ? SAT : csLowCnt  + 1'b1);
      oeLowCnt  <= memOeN  ? '0 : ((oeLowCnt  == SAT) ? SAT : oeLowCnt  + 1'b1);
      weLowCnt  <= memWeN  ? '0 : ((weLowCnt  == SAT) ? SAT : weLowCnt  + 1'b1);
      oeHighCnt <= !memOeN ? '0 : ((oeHighCnt == SAT) ? SAT : oeHighCnt + 1'b1);
    end
  end

  p_standby_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    memCsN |-> (memOeN && memWeN));

  p_no_we_with_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !memWeN |-> memOeN);

  p_no_drive_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !memOeN |-> !memDoutEn);

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!memCsN && $past(!memCsN)) |-> $stable(memAddr));

  p_oe_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memOeN) |-> (oeLowCnt >= CW'(OE_CYC)));

  p_cs_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memCsN) |-> (csLowCnt >= CW'(RC_CYC)));

  p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memWeN) |-> (weLowCnt >= CW'(WP_CYC)));

  p_drive_in_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !memWeN |-> memDoutEn);

  p_drive_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memWeN) |-> memDoutEn);

  p_cs_after_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memCsN) |-> $past(memWeN));

  p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memDoutEn) |-> (oeHighCnt >= CW'(TURN_CYC)));

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rspDone |=> !rspDone);

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RC_CYC(RC_CYC), .OE_CYC(OE_CYC),
  .WP_CYC(WP_CYC), .DW_CYC(DW_CYC), .TURN_CYC(TURN_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rspDone(rspDone), .memAddr(memAddr),
  .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN), .memDoutEn(memDoutEn)
);

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;

  localparam int AW = 15;
  localparam int DW = 8;
  localparam int RC = 2, OE = 1, WP = 2, DWC = 1, TURN = 1;
  localparam int RLEN = (RC > OE) ? RC : OE;
  localparam int WLEN0 = (WP > DWC) ? WP : DWC;
  localparam int WLEN = (WLEN0 > RC - 1) ? WLEN0 : RC - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic rspDone, memCsN, memOeN, memWeN, memDoutEn;
  logic [DW-1:0] rspRdata, memDout, memDin;
  logic [AW-1:0] memAddr;

  int checks = 0;
  int errors = 0;
  int modelErr = 0;

  always #4 clk = ~clk;

  asram_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .RC_CYC(RC), .OE_CYC(OE),
    .WP_CYC(WP), .DW_CYC(DWC), .TURN_CYC(TURN)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspDone(rspDone), .rspRdata(rspRdata),
    .memAddr(memAddr), .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN),
    .memDout(memDout), .memDoutEn(memDoutEn), .memDin(memDin)
  );

  // ---------------- RAM model: tagged store, late-valid read data ----------
  logic [DW-1:0] store [0:1023];
  logic [4:0]    tagQ  [0:1023];
  logic          vldQ  [0:1023];
  int mCsLow = 0, mOeLow = 0;

  function automatic logic [DW-1:0] fillOf(input logic [AW-1:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  logic [DW-1:0] rdVal;
  always_comb begin
    if (vldQ[memAddr[9:0]] && tagQ[memAddr[9:0]] == memAddr[14:10])
      rdVal = store[memAddr[9:0]];
    else
      rdVal = fillOf(memAddr);
    if (!memCsN && !memOeN && memWeN && (mCsLow + 1 >= RC) && (mOeLow + 1 >= OE))
      memDin = rdVal;
    else
      memDin = 8'hEE;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) vldQ[i] <= 1'b0;
      mCsLow <= 0;
      mOeLow <= 0;
    end else begin
      mCsLow <= memCsN ? 0 : mCsLow + 1;
      mOeLow <= memOeN ? 0 : mOeLow + 1;
      if (!memCsN && !memWeN) begin
        if (!memDoutEn || !memOeN) modelErr <= modelErr + 1;
        store[memAddr[9:0]] <= memDout;
        tagQ[memAddr[9:0]]  <= memAddr[14:10];
        vldQ[memAddr[9:0]]  <= 1'b1;
      end
      if (memDoutEn && !memOeN) modelErr <= modelErr + 1;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int lat);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a; reqWdata = ~d;   // R3: must have no effect
    lat = 1;
    chk("R3 latched address", 32'(memAddr), 32'(a));
    while (!rspDone && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    rd = rspRdata;
    if (!wr) repeat (TURN) @(negedge clk);
  endtask

  function automatic logic [AW-1:0] sweepAddr(input int i);
    return {5'(i ^ 21), 10'(i * 109)};
  endfunction

  function automatic logic [DW-1:0] sweepData(input int i);
    return 8'(i * 37 + 5);
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [DW-1:0] rd;
    logic [DW-1:0] lastRead;
    int lat;
    int doneCnt;

    repeat (3) @(negedge clk);
    chk("R1 reset strobes", {29'd0, memCsN, memOeN, memWeN}, 32'h7);
    chk("R1 reset driver/done", {30'd0, memDoutEn, rspDone}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle strobes", {29'd0, memCsN, memOeN, memWeN}, 32'h7);
    chk("R1 idle driver/done", {30'd0, memDoutEn, rspDone}, 32'h0);

    // read of unwritten location returns model fill pattern
    access(1'b0, 15'h7ABC, 8'h00, rd, lat);
    chk("R4 read unwritten", 32'(rd), 32'(fillOf(15'h7ABC)));
    chk("R9 read latency", 32'(lat), 32'(RLEN + 1));
    chk("R1 idle after read", {29'd0, memCsN, memOeN, memWeN}, 32'h7);

    // walking-ones address, write then immediate readback
    for (int b = 0; b < AW; b++) begin
      access(1'b1, AW'(1) << b, 8'(b * 17 + 3), rd, lat);
      chk("R9 write latency", 32'(lat), 32'(WLEN + 1));
      access(1'b0, AW'(1) << b, 8'h00, rd, lat);
      chk("R5 walking readback", 32'(rd), 32'(b * 17 + 3));
    end

    // sweep: write block, read back in reverse
    for (int i = 0; i < 256; i++) begin
      access(1'b1, sweepAddr(i), sweepData(i), rd, lat);
      if (i < 8) chk("R9 write latency sweep", 32'(lat), 32'(WLEN + 1));
    end
    for (int i = 255; i >= 0; i--) begin
      access(1'b0, sweepAddr(i), 8'h00, rd, lat);
      chk("R4 sweep readback", 32'(rd), 32'(sweepData(i)));
      if (i > 247) chk("R9 read latency sweep", 32'(lat), 32'(RLEN + 1));
    end
    lastRead = rd;

    // R7: a write leaves rspRdata untouched
    access(1'b1, 15'h0123, 8'hC3, rd, lat);
    chk("R7 rdata held over write", 32'(rspRdata), 32'(lastRead));

    // R10: request raised mid-access is ignored
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 15'h2AAA; reqWdata = 8'h99;
    @(negedge clk);
    reqWrite = 1'b0; reqAddr = 15'h1555;   // still high: busy now
    doneCnt = 0;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R10 address kept while busy", 32'(memAddr), 32'h2AAA);
    for (int k = 0; k < 12; k++) begin
      if (rspDone) doneCnt++;
      @(negedge clk);
    end
    chk("R10 single done", 32'(doneCnt), 32'd1);
    access(1'b0, 15'h1555, 8'h00, rd, lat);
    chk("R10 ignored read did not write", 32'(rd), 32'(fillOf(15'h1555)));
    access(1'b0, 15'h2AAA, 8'h00, rd, lat);
    chk("R5 write during ignore test", 32'(rd), 32'h99);

    repeat (3) @(negedge clk);
    chk("R2 model protocol violations", 32'(modelErr), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule